// File: doc/BRIEF.md
# ROM Row Partition Selector

This block decides which row of a read-only memory feeds the signature compactor during a built-in self-test sweep. The address generator steps the row address upward by one every clock. The selector then raises a single-cycle `observe` strobe in exactly one row of every segment of S consecutive rows, where S = 2^N and N is half the row address width. One full sweep with a fixed pair of partition and group indices therefore picks R/S rows. Sweeping all S partition values for one group covers every row exactly once. The group index changes how partitions interleave from segment to segment, so a fault that one group aliases can be isolated by another.

The row chosen in segment k of a run is the one whose low N address bits equal an offset. In the first segment the offset is the partition index alone. In every later segment it is the partition index XOR the state of an N-bit LFSR (the diffractor). The diffractor is seeded with the group index when the run starts and takes one step at each later segment boundary. A down-counter is loaded with the offset at each boundary, and a small controller with states ST_IDLE, ST_COUNT and ST_HELD fires the strobe when the count is used up. The transitions are:
- ST_IDLE to ST_COUNT or ST_HELD on a run start.
- ST_COUNT to ST_HELD when the count reaches zero and the strobe fires.
- ST_COUNT or ST_HELD back to ST_COUNT or ST_HELD on a segment reload.
- ST_IDLE stays put until a run starts.

Top module: `rom_row_part_sel`

## Requirements
- R1: After reset, and until a run has started, `observe` stays low whatever the row address does.
- R2: A run starts only in a cycle where `run_start` is 1 and the whole `row_addr` is 0. `run_start` in any other cycle is ignored.
- R3: In the first segment of a run the offset equals the partition index, so partition 0 strobes row 0 of the run in the same cycle as the start.
- R4: In segment k≥1 the offset is `part ^ d_k`. Here d_1 is the group index and d_(k+1) = {^(d_k & TAPS), d_k[N-1:1]}. With the default N=2 and TAPS=2'b11 the diffractor steps 3→1→2→3, so group 3 with partition 2 strobes rows 2, 5, 11 and 12.
- R5: `observe` is high in the cycle whose row address has low N bits equal to the current segment's offset. It depends combinationally on that cycle's address, so an offset of 0 strobes the segment's first row.
- R6: Exactly one strobe occurs per segment. After it, the counter holds at zero and the strobe stays low until the next segment boundary.
- R7: The partition and group indices are captured at the run start. Changes on `part_idx` or `group_idx` during the run have no effect on which rows are strobed.
- R8: For one group, the S runs with partitions 0..S-1 together strobe every row of the array exactly once.
- R9: A new run start at row 0 abandons the old run and reseeds from the new indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| row_addr | input | ROW_AW | Current row address of the sweep |
| run_start | input | 1 | Begins a run when row_addr is 0 |
| part_idx | input | ROW_AW/2 | Partition index |
| group_idx | input | ROW_AW/2 | Group index, seeds the diffractor |
| observe | output | 1 | High for the one selected row of each segment |

## Verification
A corrupted offset count or a mis-stepped diffractor moves the strobe to a different row. This shows up within the same segment, at most S cycles after the fault, as an unexpected or missing `observe`. The scoreboard compares each strobe with the row it predicted from the formula. A stale partition register or a wrong seed shows up from segment one onward, and it also breaks the one-hit-per-row coverage taken over a whole group. A controller stuck outside ST_HELD shows up as a second strobe within the segment.

// File: rtl/rps_pkg.sv
package rps_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_HELD  = 2'd2
    } ofs_state_e;
endpackage

// File: rtl/rps_diffractor.sv
module rps_diffractor #(
    parameter int          N    = 2,
    parameter logic [N-1:0] TAPS = 2'b11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         seed_load,
    input  logic [N-1:0] seed,
    input  logic         step,
    output logic [N-1:0] state
);
    logic feedback;

    assign feedback = ^(state & TAPS);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= '0;
        end else if (seed_load) begin
            state <= seed;
        end else if (step) begin
            state <= {feedback, state[N-1:1]};
        end
    end
endmodule

// File: rtl/rps_offset_ctl.sv
module rps_offset_ctl
    import rps_pkg::*;
#(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         seg_start,
    input  logic         run_begin,
    input  logic [N-1:0] load_val,
    output logic         active,
    output logic         observe
);
    ofs_state_e   st_q, st_n;
    logic [N-1:0] cnt_q, cnt_n;
    logic         reload;

    assign reload = seg_start && (run_begin || st_q != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        if (reload) begin
            if (load_val == '0) begin
                st_n  = ST_HELD;
                cnt_n = '0;
            end else begin
                st_n  = ST_COUNT;
                cnt_n = load_val - 1'b1;
            end
        end else begin
            unique case (st_q)
                ST_IDLE:  st_n = ST_IDLE;
                ST_COUNT: begin
                    if (cnt_q == '0) begin
                        st_n = ST_HELD;
                    end else begin
                        cnt_n = cnt_q - 1'b1;
                    end
                end
                ST_HELD:  st_n = ST_HELD;
                default:  st_n = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        active = (st_q != ST_IDLE);
        if (reload) begin
            observe = (load_val == '0);
        end else begin
            observe = (st_q == ST_COUNT) && (cnt_q == '0);
        end
    end
endmodule

// File: rtl/rom_row_part_sel.sv
module rom_row_part_sel #(
    parameter int                  ROW_AW = 4,
    parameter logic [ROW_AW/2-1:0] TAPS   = 2'b11
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ROW_AW-1:0]   row_addr,
    input  logic                run_start,
    input  logic [ROW_AW/2-1:0] part_idx,
    input  logic [ROW_AW/2-1:0] group_idx,
    output logic                observe
);
    localparam int N = ROW_AW / 2;

    logic         seg_start;
    logic         run_begin;
    logic         active;
    logic [N-1:0] part_q;
    logic [N-1:0] diff_state;
    logic [N-1:0] diff_gated;
    logic [N-1:0] load_val;

    assign seg_start  = (row_addr[N-1:0] == '0);
    assign run_begin  = run_start && (row_addr == '0);
    assign diff_gated = diff_state & {N{~run_begin}};
    assign load_val   = run_begin ? part_idx : (part_q ^ diff_gated);

    always_ff @(posedge clk) begin
        if (rst) begin
            part_q <= '0;
        end else if (run_begin) begin
            part_q <= part_idx;
        end
    end

    rps_diffractor #(.N(N), .TAPS(TAPS)) u_diff (
        .clk       (clk),
        .rst       (rst),
        .seed_load (run_begin),
        .seed      (group_idx),
        .step      (seg_start && active && !run_begin),
        .state     (diff_state)
    );

    rps_offset_ctl #(.N(N)) u_ofs (
        .clk       (clk),
        .rst       (rst),
        .seg_start (seg_start),
        .run_begin (run_begin),
        .load_val  (load_val),
        .active    (active),
        .observe   (observe)
    );
endmodule

// File: rtl/rps_checker.sv
module rps_checker #(
    parameter int ROW_AW = 4
) (
    input logic                clk,
    input logic                rst,
    input logic [ROW_AW-1:0]   row_addr,
    input logic                run_start,
    input logic [ROW_AW/2-1:0] part_idx,
    input logic [ROW_AW/2-1:0] group_idx,
    input logic [ROW_AW/2-1:0] diff_state,
    input logic                observe
);
    localparam int N = ROW_AW / 2;

    logic       seg_s;
    logic       begin_s;
    logic       started;
    logic [2:0] hits;

    assign seg_s   = (row_addr[N-1:0] == '0);
    assign begin_s = run_start && (row_addr == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            started <= 1'b0;
            hits    <= '0;
        end else begin
            if (begin_s) started <= 1'b1;
            if (seg_s) hits <= {2'b00, observe};
            else if (observe && hits != 3'd7) hits <= hits + 3'd1;
        end
    end

    AST_QUIET_BEFORE_RUN: assert property (@(posedge clk) disable iff (rst)
        (!started && !begin_s) |-> !observe); // R1
    AST_FIRST_OFFSET_ZERO: assert property (@(posedge clk) disable iff (rst)
        (begin_s && part_idx == '0) |-> observe); // R3
    AST_SEED_GROUP: assert property (@(posedge clk) disable iff (rst)
        begin_s |=> (diff_state == $past(group_idx))); // R4
    AST_NO_SECOND_HIT: assert property (@(posedge clk) disable iff (rst)
        (observe && !seg_s) |-> (hits == '0)); // R6
    AST_ONE_HIT_PER_SEG: assert property (@(posedge clk) disable iff (rst)
        (seg_s && started) |-> (hits == 3'd1)); // R6
endmodule

bind rom_row_part_sel rps_checker #(.ROW_AW(ROW_AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .row_addr   (row_addr),
    .run_start  (run_start),
    .part_idx   (part_idx),
    .group_idx  (group_idx),
    .diff_state (diff_state),
    .observe    (observe)
);

// File: tb/rom_row_part_sel_bench.sv
module rom_row_part_sel_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] row_addr;
    logic       run_start;
    logic [1:0] part_idx;
    logic [1:0] group_idx;
    logic       observe;

    int    n_checks = 0;
    int    n_errs   = 0;
    int    exp_q[$];
    int    hit_cnt[16];
    int    mon_e;
    string cur_tag = "R1";
    bit    finished = 1'b0;

    bit       m_started = 1'b0;
    logic [1:0] m_p, m_diff;
    int       m_off;

    always #10 clk = ~clk;

    rom_row_part_sel u_rom_row_part_sel (
        .clk       (clk),
        .rst       (rst),
        .row_addr  (row_addr),
        .run_start (run_start),
        .part_idx  (part_idx),
        .group_idx (group_idx),
        .observe   (observe)
    );

    function automatic logic [1:0] lfsr_next(logic [1:0] s);
        return {s[1] ^ s[0], s[1]};
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every strobe
    always @(negedge clk) begin
        if (!rst && observe) begin
            hit_cnt[row_addr]++;
            if (exp_q.size() == 0) begin
                check(1'b0, cur_tag, int'(row_addr), -1);
            end else begin
                mon_e = exp_q.pop_front();
                check(int'(row_addr) == mon_e, cur_tag, int'(row_addr), mon_e);
            end
        end
    end

    // driver: applies one row and pushes the expected strobe
    task automatic step(int row, bit st, int p, int g);
        @(posedge clk);
        #1;
        row_addr  = row[3:0];
        run_start = st;
        part_idx  = p[1:0];
        group_idx = g[1:0];
        if (row == 0 && st) begin
            m_started = 1'b1;
            m_p       = p[1:0];
            m_diff    = g[1:0];
            m_off     = p;
        end else if (row % 4 == 0 && m_started) begin
            m_off  = int'(m_p ^ m_diff);
            m_diff = lfsr_next(m_diff);
        end
        if (m_started && (row % 4) == m_off) exp_q.push_back(row);
    endtask

    task automatic run(int from, int n, bit st, int p, int g);
        for (int i = 0; i < n; i++) step((from + i) % 16, st && (i == 0), p, g);
    endtask

    task automatic phase_end(string tag);
        @(negedge clk);
        #1;
        check(exp_q.size() == 0, tag, exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic clear_hits();
        for (int i = 0; i < 16; i++) hit_cnt[i] = 0;
    endtask

    initial begin
        rst = 1'b1; row_addr = '0; run_start = 1'b0; part_idx = '0; group_idx = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(observe == 1'b0, "R1", int'(observe), 0);
        @(posedge clk);
        #1 rst = 1'b0;

        // R1: no run started, nothing observed
        cur_tag = "R1";
        run(0, 16, 1'b0, 2, 3);
        phase_end("R1");

        // R2: start with nonzero address is ignored
        cur_tag = "R2";
        step(1, 1'b1, 2, 3);
        run(2, 14, 1'b0, 2, 3);
        phase_end("R2");

        // R4 / R5: group 3 partition 2 gives rows 2, 5, 11, 12
        cur_tag = "R4";
        run(0, 16, 1'b1, 2, 3);
        phase_end("R4");
        cur_tag = "R5";
        run(0, 16, 1'b1, 1, 3);
        phase_end("R5");

        // R3: partition 0 strobes row 0 in the start cycle
        cur_tag = "R3";
        run(0, 16, 1'b1, 0, 2);
        phase_end("R3");

        // R8: every row exactly once per group
        for (int g = 0; g < 4; g++) begin
            clear_hits();
            cur_tag = "R8";
            for (int p = 0; p < 4; p++) run(0, 16, 1'b1, p, g);
            phase_end("R8");
            for (int r = 0; r < 16; r++) check(hit_cnt[r] == 1, "R8", hit_cnt[r], 1);
        end

        // R6: exactly one strobe in each segment
        clear_hits();
        cur_tag = "R6";
        run(0, 16, 1'b1, 1, 1);
        phase_end("R6");
        for (int s = 0; s < 4; s++)
            check(hit_cnt[4*s] + hit_cnt[4*s+1] + hit_cnt[4*s+2] + hit_cnt[4*s+3] == 1,
                  "R6", hit_cnt[4*s] + hit_cnt[4*s+1] + hit_cnt[4*s+2] + hit_cnt[4*s+3], 1);

        // R7: index changes mid-run are ignored
        cur_tag = "R7";
        run(0, 6, 1'b1, 1, 2);
        run(6, 10, 1'b0, 3, 0);
        phase_end("R7");

        // R9: restart reseeds from new indices
        cur_tag = "R9";
        run(0, 7, 1'b1, 0, 1);
        run(0, 16, 1'b1, 3, 3);
        phase_end("R9");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end
endmodule